// File: doc/BRIEF.md
# Rotated 8-bit Immediate Encoder

This block decides whether a 32-bit constant can be expressed as an 8-bit payload rotated right by an even number of bit positions. When it can, the block emits a 12-bit code. The upper four bits of the code hold half the rotate amount and the lower eight bits hold the payload. The window search tries the trailing-zero position first. If that fails, it tries a second position that catches payloads wrapping from bit 31 into bit 0.

When a constant does not fit a single rotated payload, the block checks whether it splits into two. It removes the bits covered by the first chosen window and searches again on the remainder. If the split works, both 32-bit parts are presented. OR-ing the parts together gives back the input.

The block is used by an instruction-building datapath that needs to materialise constants. A parameter selects a registered output stage, which is the default, or a purely combinational path.

Top module: `rot8_imm_encoder`

## Requirements
- R1: An input with bits 31:8 all zero is encodable, and its code is {4'b0000, input[7:0]}.
- R2: The encodable flag is high exactly when some even rotation R (0 to 30) and payload p give input = p rotated right by R. The code is then {R/2 in bits 11:8, p in bits 7:0}, and rotating code[7:0] right by 2*code[11:8] reproduces the input.
- R3: The window is chosen as follows:
  - The first candidate left-rotation is the trailing-zero count rounded down to even.
  - If that candidate fails and input[5:0] is non-zero, the trailing-zero count is taken again with bits 5:0 cleared.
  - The code's rotate amount is (32 minus the candidate) mod 32.
  - Examples: 0x00000100 gives 0xC01, 0xF000000F gives 0x2FF, 0x80000001 gives 0x106, and 0x00AB0000 gives 0x8AB.
- R4: When the input is not encodable, the encodable flag is low and the code is zero.
- R5: The two-part flag is high only under both of these conditions:
  - the bits outside the first chosen window are non-zero;
  - after a second window search on those bits, nothing is left.

  The flag is never high together with the encodable flag. For example, 0x000001FE and 0xFF0000FF give 1, while 0x01010101, 0xFFFFFFFF and 0 give 0.
- R6: When the two-part flag is high, part A is the input masked by the first window and part B is the rest. The parts are disjoint, their OR equals the input, and each is single-encodable. For example, 0x000001FE splits into 0xFE and 0x100, and 0xFF0000FF splits into 0xFF and 0xFF000000. When the two-part flag is low, both parts are zero.
- R7: With the registered stage, the output valid flag equals the input strobe of the previous cycle. The results describe the value presented with that strobe. Results hold unchanged while the strobe is low.
- R8: While reset is asserted, the valid flag, both result flags, the code and both parts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe qualifying in_value |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | Result qualifier |
| out_encodable | output | 1 | Constant fits one rotated payload |
| out_code | output | 12 | {rotate/2, payload} when encodable, else zero |
| out_two_part | output | 1 | Constant splits into two rotated payloads |
| out_part_a | output | 32 | First part (first window) when split, else zero |
| out_part_b | output | 32 | Remainder part when split, else zero |

## Verification
The bench builds the block with its default registered output stage. This brings the one-cycle strobe-to-result delay and the hold of results across idle cycles within reach of the scoreboard.

Random payloads at every even rotation exercise wrap-around windows. ORs of two such payloads hit the split path. Directed constants pin down the exact window choice and part values.

The combinational variant shares all the encoding logic, and the bound checker covers its data relations whenever it is elaborated.

// File: rtl/rot8_imm_encoder.sv
module rot8_imm_encoder #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_value,
  output logic        out_valid,
  output logic        out_encodable,
  output logic [11:0] out_code,
  output logic        out_two_part,
  output logic [31:0] out_part_a,
  output logic [31:0] out_part_b
);
  localparam int WORD_W = 32;
  localparam int PAY_W  = 8;
  localparam int CODE_W = 12;
  localparam logic [WORD_W-1:0] PAY_MASK = WORD_W'((1 << PAY_W) - 1);
  localparam logic [WORD_W-1:0] WRAP_MASK = WORD_W'(6'h3F);

  function automatic logic [WORD_W-1:0] ror32(input logic [WORD_W-1:0] v, input logic [4:0] a);
    return (v >> a) | (v << (6'd32 - {1'b0, a}));
  endfunction

  function automatic logic [WORD_W-1:0] rol32(input logic [WORD_W-1:0] v, input logic [4:0] a);
    return (v << a) | (v >> (6'd32 - {1'b0, a}));
  endfunction

  function automatic logic [4:0] tz32(input logic [WORD_W-1:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = WORD_W - 1; i >= 0; i--)
      if (v[i]) n = 5'(i);
    return n;
  endfunction

  function automatic logic [4:0] pick_rot(input logic [WORD_W-1:0] v);
    logic [4:0] ra, rb;
    if ((v & ~PAY_MASK) == '0) return 5'd0;
    ra = tz32(v) & 5'b11110;
    if ((ror32(v, ra) & ~PAY_MASK) == '0) return 5'd0 - ra;
    if ((v & WRAP_MASK) != '0) begin
      rb = tz32(v & ~WRAP_MASK) & 5'b11110;
      if ((ror32(v, rb) & ~PAY_MASK) == '0) return 5'd0 - rb;
    end
    return 5'd0 - ra;
  endfunction

  logic [4:0]        rot1, rot2;
  logic [WORD_W-1:0] win1, rest1, rest2, aligned;
  logic              enc_c, two_c;
  logic [CODE_W-1:0] code_c;
  logic [WORD_W-1:0] pa_c, pb_c;

  assign rot1    = pick_rot(in_value);
  assign win1    = ror32(PAY_MASK, rot1);
  assign rest1   = in_value & ~win1;
  assign aligned = rol32(in_value, rot1);
  assign enc_c   = (rest1 == '0);
  assign code_c  = enc_c ? {rot1[4:1], aligned[PAY_W-1:0]} : '0;

  assign rot2    = pick_rot(rest1);
  assign rest2   = rest1 & ~ror32(PAY_MASK, rot2);
  assign two_c   = (rest1 != '0) && (rest2 == '0);
  assign pa_c    = two_c ? (in_value & win1) : '0;
  assign pb_c    = two_c ? rest1 : '0;

  if (OUT_REG) begin : g_reg
    logic              vld_q, enc_q, two_q;
    logic [CODE_W-1:0] code_q;
    logic [WORD_W-1:0] pa_q, pb_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        enc_q  <= 1'b0;
        two_q  <= 1'b0;
        code_q <= '0;
        pa_q   <= '0;
        pb_q   <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) begin
          enc_q  <= enc_c;
          two_q  <= two_c;
          code_q <= code_c;
          pa_q   <= pa_c;
          pb_q   <= pb_c;
        end
      end
    end

    assign out_valid     = vld_q;
    assign out_encodable = enc_q;
    assign out_two_part  = two_q;
    assign out_code      = code_q;
    assign out_part_a    = pa_q;
    assign out_part_b    = pb_q;
  end else begin : g_comb
    assign out_valid     = in_valid;
    assign out_encodable = enc_c;
    assign out_two_part  = two_c;
    assign out_code      = code_c;
    assign out_part_a    = pa_c;
    assign out_part_b    = pb_c;
  end
endmodule

// File: rtl/rot8_imm_encoder_chk.sv
module rot8_imm_encoder_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_value,
  input logic        out_valid,
  input logic        out_encodable,
  input logic [11:0] out_code,
  input logic        out_two_part,
  input logic [31:0] out_part_a,
  input logic [31:0] out_part_b
);
  function automatic logic [31:0] unpack(input logic [11:0] c);
    logic [4:0]  r;
    logic [31:0] p;
    r = {c[11:8], 1'b0};
    p = {24'd0, c[7:0]};
    return (p >> r) | (p << (6'd32 - {1'b0, r}));
  endfunction

  logic [31:0] cap;
  logic [31:0] ref_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap <= '0;
    else if (in_valid) cap <= in_value;

  assign ref_val = OUT_REG ? cap : in_value;

  assert_small_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ref_val[31:8] == 24'd0) |-> (out_encodable && out_code == {4'd0, ref_val[7:0]}));

  assert_code_rebuilds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_encodable) |-> (unpack(out_code) == ref_val));

  assert_code_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_encodable |-> (out_code == 12'd0));

  assert_split_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_two_part |-> (!out_encodable && out_part_b != 32'd0));

  assert_parts_join_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_two_part) |-> (((out_part_a & out_part_b) == 32'd0) && ((out_part_a | out_part_b) == ref_val)));

  assert_parts_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_two_part |-> (out_part_a == 32'd0 && out_part_b == 32'd0));

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && in_valid) |=> out_valid);

  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !in_valid) |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !in_valid) |=> ($stable(out_code) && $stable(out_encodable) && $stable(out_two_part)
                                && $stable(out_part_a) && $stable(out_part_b)));
endmodule

bind rot8_imm_encoder rot8_imm_encoder_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
  .out_valid(out_valid), .out_encodable(out_encodable), .out_code(out_code),
  .out_two_part(out_two_part), .out_part_a(out_part_a), .out_part_b(out_part_b)
);

// File: tb/test_rot8_imm_encoder.sv
`timescale 1ns/1ps
module test_rot8_imm_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_value = '0;
  logic        out_valid, out_encodable, out_two_part;
  logic [11:0] out_code;
  logic [31:0] out_part_a, out_part_b;

  rot8_imm_encoder i_rot8_imm_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .out_valid(out_valid), .out_encodable(out_encodable), .out_code(out_code),
    .out_two_part(out_two_part), .out_part_a(out_part_a), .out_part_b(out_part_b)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] v;
    bit          dir;
    logic [11:0] code;
    bit          two;
    logic [31:0] pa;
    logic [31:0] pb;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] rr(input logic [31:0] v, input int a);
    int s;
    s = a % 32;
    if (s == 0) return v;
    return (v >> s) | (v << (32 - s));
  endfunction

  function automatic bit fits(input logic [31:0] v);
    for (int r = 0; r < 32; r += 2)
      if ((rr(v, 32 - r) & 32'hFFFF_FF00) == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] v, input bit dir, input logic [11:0] code,
                      input bit two, input logic [31:0] pa, input logic [31:0] pb);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_value = v;
    it.v = v; it.dir = dir; it.code = code; it.two = two; it.pa = pa; it.pb = pb;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_value = $urandom;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  logic [11:0] last_code = '0;
  logic        last_enc = 1'b0, last_two = 1'b0;
  logic [31:0] last_pa = '0, last_pb = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected valid", 32'd1, 32'd0);
        end else begin
          item_t it;
          bit    e;
          it = q.pop_front();
          e  = fits(it.v);
          chk(out_encodable == e, "R2 encodable flag", 32'(out_encodable), 32'(e));
          if (e)
            chk(rr({24'd0, out_code[7:0]}, 2 * int'(out_code[11:8])) == it.v, "R2 code rebuild",
                rr({24'd0, out_code[7:0]}, 2 * int'(out_code[11:8])), it.v);
          if (it.v[31:8] == 0)
            chk(out_code == {4'd0, it.v[7:0]}, "R1 small value code", 32'(out_code), 32'({4'd0, it.v[7:0]}));
          if (!e)
            chk(out_code == 0, "R4 code zero", 32'(out_code), 32'd0);
          if (out_two_part) begin
            chk(!out_encodable, "R5 split excludes single", 32'(out_encodable), 32'd0);
            chk((out_part_a & out_part_b) == 0 && (out_part_a | out_part_b) == it.v,
                "R6 parts join", out_part_a | out_part_b, it.v);
            chk(fits(out_part_a) && fits(out_part_b), "R6 parts encodable", out_part_a, out_part_b);
          end else begin
            chk(out_part_a == 0 && out_part_b == 0, "R6 parts zero", out_part_a | out_part_b, 32'd0);
          end
          if (it.dir) begin
            chk(out_code == it.code, "R3 window choice", 32'(out_code), 32'(it.code));
            chk(out_two_part == it.two, "R5 split flag", 32'(out_two_part), 32'(it.two));
            chk(out_part_a == it.pa, "R6 part A", out_part_a, it.pa);
            chk(out_part_b == it.pb, "R6 part B", out_part_b, it.pb);
          end
        end
        last_code = out_code; last_enc = out_encodable; last_two = out_two_part;
        last_pa = out_part_a; last_pb = out_part_b;
      end else begin
        chk(out_code == last_code && out_encodable == last_enc && out_two_part == last_two
            && out_part_a == last_pa && out_part_b == last_pb,
            "R7 hold while idle", 32'(out_code), 32'(last_code));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_encodable == 0 && out_two_part == 0, "R8 reset flags",
        32'({out_valid, out_encodable, out_two_part}), 32'd0);
    chk(out_code == 0 && out_part_a == 0 && out_part_b == 0, "R8 reset data",
        out_part_a | out_part_b | 32'(out_code), 32'd0);
    rst_n = 1'b1;
    idle(2);
    // R1, R3, R4, R5, R6 directed
    send(32'h0000_0000, 1, 12'h000, 0, 32'h0, 32'h0);
    send(32'h0000_00FF, 1, 12'h0FF, 0, 32'h0, 32'h0);
    send(32'h0000_0100, 1, 12'hC01, 0, 32'h0, 32'h0);
    send(32'hF000_000F, 1, 12'h2FF, 0, 32'h0, 32'h0);
    send(32'h8000_0001, 1, 12'h106, 0, 32'h0, 32'h0);
    send(32'h00AB_0000, 1, 12'h8AB, 0, 32'h0, 32'h0);
    idle(3);
    send(32'h0000_01FE, 1, 12'h000, 1, 32'h0000_00FE, 32'h0000_0100);
    send(32'hFF00_00FF, 1, 12'h000, 1, 32'h0000_00FF, 32'hFF00_0000);
    send(32'h0101_0101, 1, 12'h000, 0, 32'h0, 32'h0);
    send(32'hFFFF_FFFF, 1, 12'h000, 0, 32'h0, 32'h0);
    idle(2);
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      a = rr({24'd0, 8'($urandom)}, 2 * $urandom_range(0, 15));
      b = rr({24'd0, 8'($urandom)}, 2 * $urandom_range(0, 15));
      case (n % 3)
        0: send(a, 0, 0, 0, 0, 0);
        1: send(a | b, 0, 0, 0, 0, 0);
        default: send($urandom, 0, 0, 0, 0, 0);
      endcase
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    chk(q.size() == 0, "R7 all results delivered", 32'(q.size()), 32'd0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule